// File: doc/BRIEF.md
# Clustered Multiport Integer Register File

This block holds the physical integer registers of an out-of-order core and serves six reads and three writes every cycle. Its registers are grouped into clusters of fixed size. For each read port, the address is first decoded into a cluster number and a one-hot enable inside that cluster. Inside each cluster, every read port has a local line built as an AND-OR of that cluster's registers under the enable. A second-level multiplexer then picks the line of the addressed cluster. This replaces one flat selector over all registers with two shallow selectors.

Read results are captured in output flops, which gives a register-read pipeline stage of its own that follows issue-select. An address presented in cycle N produces data in cycle N+1. Each read port works as a valid-qualified stream with no ready signal. `rd_en` marks a request, and `rd_valid` marks its result one cycle later. The block never applies back-pressure, so the consumer must take every result in the cycle it appears. Writes are plain enables that commit on the rising clock edge. Forwarding of values written in the same cycle is left to logic outside the block.

Top module: `rf_clustered`

## Requirements
- R1: After reset, every register reads as zero, and `rd_valid`, `rd_err` and `rd_data` are all zero.
- R2: A read requested in cycle N, with `rd_en` high, sets `rd_valid` high in cycle N+1. The result carries the value that the latest write committed before the edge ending cycle N.
- R3: The six read ports operate independently in the same cycle. Any mix of addresses is allowed, including all ports reading the same register.
- R4: Up to three writes to distinct registers commit together on one clock edge. Two enabled writes to the same register in one cycle are illegal.
- R5: A read of a register that is being written in the same cycle returns the value held before that write.
- R6: Register 0 always reads as zero, and writes to it are ignored.
- R7: A read address of 70 or higher returns zero data, and `rd_err` is high alongside `rd_valid`.
- R8: A port with `rd_en` low shows `rd_valid`, `rd_err` and its `rd_data` slice all at zero in the following cycle.
- R9: A write port with `wr_en` low leaves every register unchanged, whatever its address and data.
- R10: Registers on either side of a cluster boundary (default size 10: registers 9/10, 19/20, 59/60 and the last register, 69) read back exactly what was written to them.
- R11: Port k uses bits [7k+6:7k] of `rd_addr` and of `wr_addr`, bits [64k+63:64k] of `rd_data` and `wr_data`, and bit k of `rd_en`, `wr_en`, `rd_valid` and `rd_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and read capture occur on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 3 | Write enable, one bit per write port |
| wr_addr | input | 21 | Write addresses, 7 bits per port |
| wr_data | input | 192 | Write data, 64 bits per port |
| rd_en | input | 6 | Read request, one bit per read port |
| rd_addr | input | 42 | Read addresses, 7 bits per port |
| rd_valid | output | 6 | Result valid, one cycle after `rd_en` |
| rd_err | output | 6 | Address out of range flag for the result |
| rd_data | output | 384 | Read data, 64 bits per port |

## Verification
The risky overlap is a write and a read hitting the same register in the same cycle. The write commits on the very edge that captures the read, so a wrong ordering of the two would leak the new value. The bench provokes this by driving three writes to registers in different clusters while all six read ports request those same registers. It expects the pre-write values in that result and the new values in the next cycle. The bench's own shadow array judges both results: it takes the expected values before applying the cycle's writes.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction
endpackage

// File: rtl/rf_rd_decode.sv
`timescale 1ns/1ps
module rf_rd_decode #(
  parameter int NUM_REGS = 70,
  parameter int CLUST_SZ = 10,
  parameter int ADDR_W   = 7,
  parameter int CL_W     = 3
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [CL_W-1:0]     clust,
  output logic [CLUST_SZ-1:0] local_oh,
  output logic                oor
);
  localparam int NUM_CLUST = rf_pkg::ceil_div(NUM_REGS, CLUST_SZ);

  always_comb begin
    oor      = (32'(addr) >= 32'(NUM_REGS));
    clust    = '0;
    local_oh = '0;
    for (int c = 0; c < NUM_CLUST; c++) begin
      if (32'(addr) >= 32'(c * CLUST_SZ) && 32'(addr) < 32'((c + 1) * CLUST_SZ)) begin
        clust    = CL_W'(c);
        local_oh = CLUST_SZ'(1) << (32'(addr) - 32'(c * CLUST_SZ));
      end
    end
    if (oor) local_oh = '0;
  end
endmodule

// File: rtl/rf_cluster.sv
`timescale 1ns/1ps
module rf_cluster #(
  parameter int DATA_W   = 64,
  parameter int CLUST_SZ = 10,
  parameter int BASE     = 0,
  parameter int NUM_REGS = 70,
  parameter int NUM_RD   = 6,
  parameter int NUM_WR   = 3,
  parameter int ADDR_W   = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_WR-1:0]          wr_en,
  input  logic [NUM_WR*ADDR_W-1:0]   wr_addr,
  input  logic [NUM_WR*DATA_W-1:0]   wr_data,
  input  logic [NUM_RD*CLUST_SZ-1:0] rd_oh,
  output logic [NUM_RD*DATA_W-1:0]   rd_line
);
  logic [CLUST_SZ*DATA_W-1:0] cell_q;

  for (genvar e = 0; e < CLUST_SZ; e++) begin : g_cell
    if (BASE + e == 0 || BASE + e >= NUM_REGS) begin : g_tie
      assign cell_q[e*DATA_W +: DATA_W] = '0;
    end else begin : g_ff
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else begin
          for (int w = 0; w < NUM_WR; w++) begin
            if (wr_en[w] && wr_addr[w*ADDR_W +: ADDR_W] == ADDR_W'(BASE + e))
              q <= wr_data[w*DATA_W +: DATA_W];
          end
        end
      end
      assign cell_q[e*DATA_W +: DATA_W] = q;
    end
  end

  // Local bitline per read port: one-hot gated AND-OR over the cluster.
  always_comb begin
    rd_line = '0;
    for (int p = 0; p < NUM_RD; p++) begin
      for (int e = 0; e < CLUST_SZ; e++) begin
        rd_line[p*DATA_W +: DATA_W] = rd_line[p*DATA_W +: DATA_W]
          | ({DATA_W{rd_oh[p*CLUST_SZ + e]}} & cell_q[e*DATA_W +: DATA_W]);
      end
    end
  end
endmodule

// File: rtl/rf_xclust_mux.sv
`timescale 1ns/1ps
module rf_xclust_mux #(
  parameter int DATA_W    = 64,
  parameter int NUM_CLUST = 7,
  parameter int CL_W      = 3
) (
  input  logic [NUM_CLUST*DATA_W-1:0] lines,
  input  logic [CL_W-1:0]             sel,
  output logic [DATA_W-1:0]           data
);
  always_comb begin
    data = '0;
    for (int c = 0; c < NUM_CLUST; c++) begin
      if (sel == CL_W'(c)) data = lines[c*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/rf_clustered.sv
`timescale 1ns/1ps
module rf_clustered #(
  parameter int NUM_REGS = 70,
  parameter int DATA_W   = 64,
  parameter int NUM_RD   = 6,
  parameter int NUM_WR   = 3,
  parameter int CLUST_SZ = 10,
  parameter int ADDR_W   = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_WR-1:0]        wr_en,
  input  logic [NUM_WR*ADDR_W-1:0] wr_addr,
  input  logic [NUM_WR*DATA_W-1:0] wr_data,
  input  logic [NUM_RD-1:0]        rd_en,
  input  logic [NUM_RD*ADDR_W-1:0] rd_addr,
  output logic [NUM_RD-1:0]        rd_valid,
  output logic [NUM_RD-1:0]        rd_err,
  output logic [NUM_RD*DATA_W-1:0] rd_data
);
  localparam int NUM_CLUST = rf_pkg::ceil_div(NUM_REGS, CLUST_SZ);
  localparam int CL_W      = rf_pkg::idx_width(NUM_CLUST);
  localparam int LINE_W    = NUM_RD * DATA_W;

  logic [NUM_RD*CL_W-1:0]       dec_clust;
  logic [NUM_RD*CLUST_SZ-1:0]   dec_oh;
  logic [NUM_RD-1:0]            dec_oor;
  logic [NUM_CLUST*LINE_W-1:0]  all_lines;
  logic [NUM_RD*DATA_W-1:0]     port_data;

  // First level: per-port address decode.
  for (genvar p = 0; p < NUM_RD; p++) begin : g_dec
    rf_rd_decode #(
      .NUM_REGS(NUM_REGS), .CLUST_SZ(CLUST_SZ), .ADDR_W(ADDR_W), .CL_W(CL_W)
    ) u_dec (
      .addr    (rd_addr[p*ADDR_W +: ADDR_W]),
      .clust   (dec_clust[p*CL_W +: CL_W]),
      .local_oh(dec_oh[p*CLUST_SZ +: CLUST_SZ]),
      .oor     (dec_oor[p])
    );
  end

  // Storage clusters with per-register read enables.
  for (genvar c = 0; c < NUM_CLUST; c++) begin : g_clu
    logic [NUM_RD*CLUST_SZ-1:0] oh_c;
    always_comb begin
      for (int p = 0; p < NUM_RD; p++) begin
        oh_c[p*CLUST_SZ +: CLUST_SZ] = (dec_clust[p*CL_W +: CL_W] == CL_W'(c))
                                       ? dec_oh[p*CLUST_SZ +: CLUST_SZ] : '0;
      end
    end
    rf_cluster #(
      .DATA_W(DATA_W), .CLUST_SZ(CLUST_SZ), .BASE(c * CLUST_SZ),
      .NUM_REGS(NUM_REGS), .NUM_RD(NUM_RD), .NUM_WR(NUM_WR), .ADDR_W(ADDR_W)
    ) u_cluster (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_oh  (oh_c),
      .rd_line(all_lines[c*LINE_W +: LINE_W])
    );
  end

  // Second level: cross-cluster selection per read port.
  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    logic [NUM_CLUST*DATA_W-1:0] lines_p;
    always_comb begin
      for (int c = 0; c < NUM_CLUST; c++)
        lines_p[c*DATA_W +: DATA_W] = all_lines[c*LINE_W + p*DATA_W +: DATA_W];
    end
    rf_xclust_mux #(
      .DATA_W(DATA_W), .NUM_CLUST(NUM_CLUST), .CL_W(CL_W)
    ) u_mux (
      .lines(lines_p),
      .sel  (dec_clust[p*CL_W +: CL_W]),
      .data (port_data[p*DATA_W +: DATA_W])
    );
  end

  // Register-read stage flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= '0;
      rd_err   <= '0;
      rd_data  <= '0;
    end else begin
      for (int p = 0; p < NUM_RD; p++) begin
        rd_valid[p] <= rd_en[p];
        rd_err[p]   <= rd_en[p] & dec_oor[p];
        rd_data[p*DATA_W +: DATA_W] <= rd_en[p] ? port_data[p*DATA_W +: DATA_W] : '0;
      end
    end
  end
endmodule

// File: rtl/rf_clustered_chk.sv
`timescale 1ns/1ps
module rf_clustered_chk #(
  parameter int NUM_REGS = 70,
  parameter int DATA_W   = 64,
  parameter int NUM_RD   = 6,
  parameter int NUM_WR   = 3,
  parameter int ADDR_W   = 7
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_WR-1:0]        wr_en,
  input logic [NUM_WR*ADDR_W-1:0] wr_addr,
  input logic [NUM_RD-1:0]        rd_en,
  input logic [NUM_RD*ADDR_W-1:0] rd_addr,
  input logic [NUM_RD-1:0]        rd_valid,
  input logic [NUM_RD-1:0]        rd_err,
  input logic [NUM_RD*DATA_W-1:0] rd_data
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  for (genvar i = 0; i < NUM_WR; i++) begin : g_wi
    for (genvar j = i + 1; j < NUM_WR; j++) begin : g_wj
      AST_WR_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[i] && wr_en[j]) |-> (wr_addr[i*ADDR_W +: ADDR_W] != wr_addr[j*ADDR_W +: ADDR_W])); // R4
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic [ADDR_W-1:0] a_p;
    logic [DATA_W-1:0] d_p;
    assign a_p = rd_addr[p*ADDR_W +: ADDR_W];
    assign d_p = rd_data[p*DATA_W +: DATA_W];

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (rd_valid[p] == $past(rd_en[p]))); // R2
    AST_OOR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (rd_err[p] == $past(rd_en[p] && (32'(a_p) >= 32'(NUM_REGS))))); // R7
    AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err[p] |-> (d_p == '0)); // R7
    AST_REG0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(rd_en[p] && a_p == '0)) |-> (d_p == '0)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid[p] |-> (d_p == '0 && !rd_err[p])); // R8
  end
endmodule

bind rf_clustered rf_clustered_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_RD(NUM_RD),
  .NUM_WR(NUM_WR), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
  .rd_err(rd_err), .rd_data(rd_data)
);

// File: tb/rf_clustered_bench.sv
`timescale 1ns/1ps
module rf_clustered_bench;
  localparam int NR = 70;
  localparam int DW = 64;
  localparam int AW = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2:0]      wr_en = '0;
  logic [3*AW-1:0] wr_addr = '0;
  logic [3*DW-1:0] wr_data = '0;
  logic [5:0]      rd_en = '0;
  logic [6*AW-1:0] rd_addr = '0;
  logic [5:0]      rd_valid;
  logic [5:0]      rd_err;
  logic [6*DW-1:0] rd_data;

  rf_clustered u_rf_clustered (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_err(rd_err), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] shadow [NR];
  int ra [6];
  int wa [3];
  logic [DW-1:0] wd [3];
  logic [5:0] ren;
  logic [2:0] wen;

  function automatic logic [DW-1:0] pat(input int r, input int g);
    return {32'(r * 40503 + g * 7919), 32'(~(r << 4)) ^ 32'(g)};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive reads and writes, predict, step, compare.
  task automatic run(input string tag);
    logic [DW-1:0] ed [6];
    logic ee [6];
    logic ev [6];
    for (int p = 0; p < 6; p++) begin
      ev[p] = ren[p];
      ee[p] = ren[p] && ra[p] >= NR;
      ed[p] = (ren[p] && ra[p] < NR) ? shadow[ra[p]] : '0;
      rd_addr[p*AW +: AW] = AW'(ra[p]);
    end
    rd_en = ren;
    for (int w = 0; w < 3; w++) begin
      wr_addr[w*AW +: AW] = AW'(wa[w]);
      wr_data[w*DW +: DW] = wd[w];
    end
    wr_en = wen;
    @(posedge clk); #2;
    for (int w = 0; w < 3; w++)
      if (wen[w] && wa[w] != 0 && wa[w] < NR) shadow[wa[w]] = wd[w];
    for (int p = 0; p < 6; p++) begin
      chk(rd_data[p*DW +: DW] === ed[p], tag, $sformatf("port%0d addr%0d data", p, ra[p]),
          rd_data[p*DW +: DW], ed[p]);
      chk({rd_valid[p], rd_err[p]} === {ev[p], ee[p]}, tag,
          $sformatf("port%0d addr%0d valid/err", p, ra[p]),
          DW'({rd_valid[p], rd_err[p]}), DW'({ev[p], ee[p]}));
    end
  endtask

  task automatic idle_io();
    ren = '0; wen = '0;
    for (int p = 0; p < 6; p++) ra[p] = 0;
    for (int w = 0; w < 3; w++) begin wa[w] = 0; wd[w] = '0; end
  endtask

  task automatic write_all(input int g, input string tag);
    for (int r = 0; r < NR; r += 3) begin
      idle_io();
      for (int w = 0; w < 3; w++) begin
        wa[w] = r + w;
        wd[w] = pat(r + w, g);
        wen[w] = (r + w < NR);
      end
      run(tag);
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < NR; r++) shadow[r] = '0;
    idle_io();
    repeat (3) @(posedge clk);
    #2;
    // R1: outputs at reset
    chk(rd_data === '0, "R1", "rd_data in reset", rd_data[DW-1:0], '0);
    chk(rd_valid === '0 && rd_err === '0, "R1", "valid/err in reset",
        DW'({rd_valid, rd_err}), '0);
    rst_n = 1'b1;
    @(posedge clk); #2;

    // R1: every register zero after reset
    for (int b = 0; b < NR; b += 6) begin
      idle_io(); ren = '1;
      for (int p = 0; p < 6; p++) ra[p] = (b + p) % NR;
      run("R1");
    end

    // R4: three concurrent writes per cycle, R6: includes a write to register 0
    write_all(1, "R4");
    for (int b = 0; b < 78; b += 6) begin
      idle_io(); ren = '1;
      for (int p = 0; p < 6; p++) ra[p] = b + p;
      run("R4");
    end

    // R6: register 0 reads zero after written
    idle_io(); ren = '1; wen = 3'b001; wa[0] = 0; wd[0] = '1;
    run("R6");
    idle_io(); ren = '1; run("R6");

    // R7: out-of-range addresses
    idle_io(); ren = '1;
    ra[0] = 70; ra[1] = 71; ra[2] = 100; ra[3] = 127; ra[4] = 69; ra[5] = 1;
    run("R7");

    // R10: cluster boundaries
    idle_io(); ren = '1;
    ra[0] = 9; ra[1] = 10; ra[2] = 19; ra[3] = 20; ra[4] = 59; ra[5] = 60;
    run("R10");
    idle_io(); ren = '1;
    ra[0] = 69; ra[1] = 60; ra[2] = 49; ra[3] = 50; ra[4] = 29; ra[5] = 30;
    run("R10");

    // R5: read and write same registers in one cycle, then R2: new value next
    idle_io(); ren = '1; wen = '1;
    wa[0] = 5; wa[1] = 15; wa[2] = 65;
    for (int w = 0; w < 3; w++) wd[w] = pat(wa[w], 2);
    ra[0] = 5; ra[1] = 15; ra[2] = 65; ra[3] = 65; ra[4] = 15; ra[5] = 5;
    run("R5");
    idle_io(); ren = '1;
    ra[0] = 65; ra[1] = 5; ra[2] = 15; ra[3] = 5; ra[4] = 65; ra[5] = 15;
    run("R2");

    // R9: disabled write ports change nothing
    idle_io(); wa[0] = 7; wa[1] = 8; wa[2] = 9;
    for (int w = 0; w < 3; w++) wd[w] = pat(wa[w], 9);
    run("R9");
    idle_io(); ren = '1; ra[0] = 7; ra[1] = 8; ra[2] = 9; ra[3] = 7;
    run("R9");

    // R8: idle ports stay quiet, even with out-of-range addresses
    idle_io(); ren = 6'b010101;
    ra[0] = 3; ra[1] = 70; ra[2] = 44; ra[3] = 127; ra[4] = 12; ra[5] = 33;
    run("R8");

    // R3: all ports on one register, then rotated full sweep with new data
    idle_io(); ren = '1;
    for (int p = 0; p < 6; p++) ra[p] = 33;
    run("R3");
    write_all(3, "R3");
    for (int b = 0; b < NR; b += 6) begin
      idle_io(); ren = '1;
      for (int p = 0; p < 6; p++) ra[p] = (b + p * 11) % NR;
      run("R3");
    end

    // R11: per-port slicing, each port reading a distinct register
    idle_io(); ren = '1;
    for (int p = 0; p < 6; p++) ra[p] = 11 * p + 2;
    run("R11");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule